// File: doc/BRIEF.md
# Shadowed Nonvolatile Register Array

This block holds a small bank of configuration registers. Each one is backed by a modelled nonvolatile word and mirrored by a volatile shadow word. A host reaches the bank through a single address bus. A write strobe and write data change a register. A combinational read port always returns the shadow copy, so a read never has to wait.

A single mode bit sits in a volatile control register placed just above the data registers. It picks how data writes behave:

- **Mode bit clear (the state after power-on).** A write updates the shadow at once. It then raises `busy` for a fixed number of cycles while the same value is committed to the nonvolatile word. Any write arriving during that window is dropped.
- **Mode bit set.** Writes touch only the shadow, cost no busy time and can follow one another on every cycle. The nonvolatile copy keeps its older value.

The power-on reset stands in for a power cycle. While it is held low, every shadow word is reloaded from its nonvolatile word, the mode bit is cleared and any commit in flight is abandoned. After reset, the host therefore sees the last values that were written with the mode bit clear and whose commit had finished.

Top module: `shadow_nvreg`

## Requirements
- R1: While `porN` is low and on the first cycle after it returns high, `busy` is 0, the mode bit reads 0, and each data register i reads its nonvolatile content. At first power-up that content is (NV_SEED + i) truncated to DATA_W bits.
- R2: `rdData` is combinational from `addr`. For an address below NUM_REGS it returns the shadow word. At address NUM_REGS it returns the mode bit in bit 0, with all other bits 0.
- R3: With the mode bit clear, an accepted write to a data address is visible on `rdData` in the next cycle. `busy` is high for exactly COMMIT_CYCLES consecutive cycles, starting the cycle after the write.
- R4: A write presented while `busy` is high changes neither a data register nor the mode bit, and does not extend the busy window.
- R5: With the mode bit set, a write to a data address updates the shadow in the next cycle and never raises `busy`, so writes on consecutive cycles are all accepted.
- R6: After a power-on reset, data registers written while the mode bit was set read back the value from their last completed clear-mode write, or their initial content if they never had one.
- R7: A power-on reset while `busy` is high abandons that commit. The nonvolatile word keeps its previous value, and `busy` drops during reset.
- R8: A write to address NUM_REGS loads only `wrData` bit 0 into the mode bit. It never raises `busy` and changes no data register.
- R9: Writes to addresses above NUM_REGS have no effect, and reads from such addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porN | input | 1 | Active-low power-on reset; models a power cycle |
| addr | input | ADDR_W | Register address for both read and write |
| wrEn | input | 1 | Write strobe |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Shadow value at `addr` (combinational) |
| busy | output | 1 | High while a nonvolatile commit is in progress |

## Verification
The hardest case to reach from the ports is a power cycle that lands inside a commit window. Only this case shows that the nonvolatile word was left untouched, while the shadow had already taken the new value. The stimulus issues a clear-mode write, waits a few cycles so that `busy` is still high, and then pulls `porN` low. It then reads the register back, expecting the prior committed value. A similar sequence sets the mode bit and performs several shadow-only writes, one of them over a register committed just before. It then cycles power, and the readback must show that the committed value survived and the shadow-only values did not.

// File: rtl/shadow_nvreg_pkg.sv
package shadow_nvreg_pkg;

  // Strobes from the control unit to the datapath.
  typedef struct packed {
    logic load;      // reload every shadow word from its nonvolatile word
    logic shadowWr;  // write wrData into the shadow word at addr
    logic capture;   // latch addr/data for a pending nonvolatile commit
    logic commit;    // write the pending value into the nonvolatile array
  } strobe_t;

endpackage

// File: rtl/shadow_nvreg_ctrl.sv
module shadow_nvreg_ctrl
  import shadow_nvreg_pkg::*;
#(
  parameter int NUM_REGS      = 8,
  parameter int COMMIT_CYCLES = 6,
  parameter int ADDR_W        = 4
) (
  input  logic              clk,
  input  logic              porN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              modeBitIn,
  output strobe_t           strb,
  output logic              busy,
  output logic              shadowEn
);

  localparam int CNT_W = $clog2(COMMIT_CYCLES + 1);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_REGS);
  localparam logic [CNT_W-1:0]  CNT_LOAD  = CNT_W'(COMMIT_CYCLES - 1);

  logic [CNT_W-1:0] remain;
  logic accept, isData, isCtrl, lastCycle;

  assign accept    = porN && wrEn && !busy;
  assign isData    = addr < CTRL_ADDR;
  assign isCtrl    = addr == CTRL_ADDR;
  assign lastCycle = busy && (remain == '0);

  always_comb begin
    strb          = '0;
    strb.load     = !porN;
    strb.shadowWr = accept && isData;
    strb.capture  = accept && isData && !shadowEn;
    strb.commit   = porN && lastCycle;
  end

  always_ff @(posedge clk) begin
    if (!porN) begin
      busy     <= 1'b0;
      remain   <= '0;
      shadowEn <= 1'b0;
    end else begin
      if (busy) begin
        if (lastCycle) busy <= 1'b0;
        else           remain <= remain - 1'b1;
      end
      if (strb.capture) begin
        busy   <= 1'b1;
        remain <= CNT_LOAD;
      end
      if (accept && isCtrl) shadowEn <= modeBitIn;
    end
  end

endmodule

// File: rtl/shadow_nvreg_dp.sv
module shadow_nvreg_dp
  import shadow_nvreg_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 4,
  parameter int NV_SEED  = 48
) (
  input  logic              clk,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              shadowEn,
  output logic [DATA_W-1:0] rdData
);

  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_REGS);

  logic [DATA_W-1:0] nvMem     [NUM_REGS];
  logic [DATA_W-1:0] shadowMem [NUM_REGS];
  logic [IDX_W-1:0]  pendIdx;
  logic [DATA_W-1:0] pendData;
  logic [IDX_W-1:0]  idx;

  assign idx = IDX_W'(addr);

  // Nonvolatile array model: content survives porN, seeded at first power-up.
  initial begin
    for (int i = 0; i < NUM_REGS; i++) nvMem[i] = DATA_W'(NV_SEED + i);
  end

  always_ff @(posedge clk) begin
    if (strb.commit) nvMem[pendIdx] <= pendData;
  end

  always_ff @(posedge clk) begin
    if (strb.capture) begin
      pendIdx  <= idx;
      pendData <= wrData;
    end
  end

  // One shadow word per register, each with its own write decode.
  for (genvar g = 0; g < NUM_REGS; g++) begin : gShadow
    logic hit;
    assign hit = strb.shadowWr && (idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (strb.load)  shadowMem[g] <= nvMem[g];
      else if (hit)   shadowMem[g] <= wrData;
    end
  end

  always_comb begin
    if (addr == CTRL_ADDR)
      rdData = {{(DATA_W-1){1'b0}}, shadowEn};
    else if (addr < CTRL_ADDR)
      rdData = shadowMem[idx];
    else
      rdData = '0;
  end

endmodule

// File: rtl/shadow_nvreg.sv
module shadow_nvreg
  import shadow_nvreg_pkg::*;
#(
  parameter int NUM_REGS      = 8,
  parameter int DATA_W        = 8,
  parameter int COMMIT_CYCLES = 6,
  parameter int NV_SEED       = 48,
  localparam int ADDR_W       = $clog2(NUM_REGS + 1)
) (
  input  logic              clk,
  input  logic              porN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              busy
);

  strobe_t strb;
  logic    shadowEn;

  shadow_nvreg_ctrl #(
    .NUM_REGS(NUM_REGS), .COMMIT_CYCLES(COMMIT_CYCLES), .ADDR_W(ADDR_W)
  ) u_ctrl (
    .clk(clk), .porN(porN), .addr(addr), .wrEn(wrEn),
    .modeBitIn(wrData[0]), .strb(strb), .busy(busy), .shadowEn(shadowEn)
  );

  shadow_nvreg_dp #(
    .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NV_SEED(NV_SEED)
  ) u_dp (
    .clk(clk), .strb(strb), .addr(addr), .wrData(wrData),
    .shadowEn(shadowEn), .rdData(rdData)
  );

endmodule

// File: rtl/shadow_nvreg_chk.sv
module shadow_nvreg_chk #(
  parameter int NUM_REGS      = 8,
  parameter int DATA_W        = 8,
  parameter int COMMIT_CYCLES = 6,
  parameter int ADDR_W        = 4
) (
  input logic              clk,
  input logic              porN,
  input logic [ADDR_W-1:0] addr,
  input logic              wrEn,
  input logic [DATA_W-1:0] rdData,
  input logic              busy,
  input logic              shadowEn
);

  int runLen;

  always_ff @(posedge clk) begin
    if (!porN)     runLen <= 0;
    else if (busy) runLen <= runLen + 1;
    else           runLen <= 0;
  end

  AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!porN)
    busy |-> runLen < COMMIT_CYCLES);  // R3

  AST_BUSY_FULL_LEN: assert property (@(posedge clk) disable iff (!porN)
    $fell(busy) |-> $past(runLen) == COMMIT_CYCLES - 1);  // R3

  AST_BUSY_CAUSE: assert property (@(posedge clk) disable iff (!porN)
    $rose(busy) |-> $past(wrEn) && !$past(shadowEn) && ($past(addr) < ADDR_W'(NUM_REGS)));  // R3

  AST_SHADOW_NO_BUSY: assert property (@(posedge clk) disable iff (!porN)
    (wrEn && !busy && shadowEn) |=> !busy);  // R5

  AST_BUSY_MODE_HOLD: assert property (@(posedge clk) disable iff (!porN)
    (busy && wrEn && addr == ADDR_W'(NUM_REGS)) |=> $stable(shadowEn));  // R4

  AST_OUT_OF_RANGE_ZERO: assert property (@(posedge clk) disable iff (!porN)
    (addr > ADDR_W'(NUM_REGS)) |-> rdData == '0);  // R9

endmodule

bind shadow_nvreg shadow_nvreg_chk #(
  .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .COMMIT_CYCLES(COMMIT_CYCLES), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .porN(porN), .addr(addr), .wrEn(wrEn),
  .rdData(rdData), .busy(busy), .shadowEn(shadowEn)
);

// File: tb/test_shadow_nvreg.sv
module test_shadow_nvreg;

  localparam int N    = 8;
  localparam int DW   = 8;
  localparam int CC   = 6;
  localparam int SEED = 48;
  localparam int AW   = $clog2(N + 1);

  logic clk = 1'b0;
  logic porN = 1'b0;
  logic [AW-1:0] addr = '0;
  logic wrEn = 1'b0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData;
  logic busy;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  shadow_nvreg #(.NUM_REGS(N), .DATA_W(DW), .COMMIT_CYCLES(CC), .NV_SEED(SEED)) i_shadow_nvreg (
    .clk(clk), .porN(porN), .addr(addr), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .busy(busy)
  );

  // Behavioural reference model
  int nvRef [N];
  int shRef [N];
  int modeRef = 0;
  int busyLeft = 0;
  int pendA = 0;
  int pendD = 0;

  initial for (int i = 0; i < N; i++) nvRef[i] = (SEED + i) % 256;

  always @(posedge clk) begin
    if (!porN) begin
      modeRef = 0;
      busyLeft = 0;
      for (int i = 0; i < N; i++) shRef[i] = nvRef[i];
    end else begin
      bit wasBusy;
      wasBusy = busyLeft > 0;
      if (wasBusy) begin
        busyLeft--;
        if (busyLeft == 0) nvRef[pendA] = pendD;
      end
      if (!wasBusy && wrEn) begin
        if (int'(addr) < N) begin
          shRef[addr] = int'(wrData);
          if (modeRef == 0) begin
            busyLeft = CC;
            pendA = int'(addr);
            pendD = int'(wrData);
          end
        end else if (int'(addr) == N) begin
          modeRef = int'(wrData[0]);
        end
      end
    end
  end

  function automatic int expRead(input int a);
    if (a < N)  return shRef[a];
    if (a == N) return modeRef;
    return 0;
  endfunction

  task automatic compare(input string tag);
    int e;
    e = expRead(int'(addr));
    checks++;
    if (int'(rdData) !== e) begin
      failures++;
      $display("FAIL %s rdData addr=%0d actual=%0h expected=%0h", tag, addr, rdData, e);
    end
    checks++;
    if (busy !== (busyLeft > 0)) begin
      failures++;
      $display("FAIL %s busy actual=%0b expected=%0b", tag, busy, busyLeft > 0);
    end
  endtask

  // Compare at the falling edge, then drive the next inputs.
  task automatic step(input int a, input bit we, input int d, input string tag);
    @(negedge clk);
    compare(tag);
    addr = AW'(a);
    wrEn = we;
    wrData = DW'(d);
  endtask

  task automatic powerCycle(input int n);
    @(negedge clk);
    wrEn = 1'b0;
    porN = 1'b0;
    repeat (n) @(negedge clk);
    porN = 1'b1;
  endtask

  initial begin
    powerCycle(3);
    // R1: reset contents and mode
    for (int i = 0; i <= N; i++) step(i, 0, 0, "R1");
    step(N, 0, 0, "R2");
    // R3: clear-mode write with commit window
    step(2, 1, 'hA5, "R3");
    step(2, 0, 0, "R3");
    // R4: writes during busy are dropped
    step(2, 1, 'h11, "R4");
    step(N, 1, 1, "R4");
    step(2, 0, 0, "R4");
    for (int i = 0; i < CC; i++) step(N, 0, 0, "R3");
    step(2, 0, 0, "R3");
    // R8: set mode bit
    step(N, 1, 'h01, "R8");
    step(N, 0, 0, "R8");
    // R5: back-to-back shadow writes
    step(2, 1, 'h5A, "R5");
    step(3, 1, 'h77, "R5");
    step(5, 1, 'h99, "R5");
    step(2, 0, 0, "R5");
    step(3, 0, 0, "R5");
    step(5, 0, 0, "R5");
    // R9: out-of-range
    step(12, 1, 'hFF, "R9");
    step(12, 0, 0, "R9");
    step(N + 1, 0, 0, "R9");
    for (int i = 0; i <= N; i++) step(i, 0, 0, "R9");
    // R6: power cycle discards shadow-only values
    powerCycle(3);
    for (int i = 0; i <= N; i++) step(i, 0, 0, "R6");
    // R7: power cycle mid-commit
    step(4, 1, 'hC3, "R7");
    step(4, 0, 0, "R7");
    step(4, 0, 0, "R7");
    powerCycle(2);
    step(4, 0, 0, "R7");
    step(4, 0, 0, "R7");
    // R8: only bit 0 of the mode write matters
    step(N, 1, 'hFF, "R8");
    step(N, 0, 0, "R8");
    step(N, 1, 'hFE, "R8");
    step(N, 0, 0, "R8");
    step(6, 1, 'h42, "R3");
    for (int i = 0; i < CC + 2; i++) step(6, 0, 0, "R3");
    @(negedge clk);
    compare("R2");
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(5 * 20000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule